// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block fetches a device's configuration image from a serial EEPROM over a two-wire (I2C) bus at power-up. It acts as the bus master. When the mode input selects self-loading and the active-low chain reset input is released, the block waits a fixed settling delay. It then reads sixteen consecutive bytes from the EEPROM and places them in a sixteen-entry configuration register file.

Four strap inputs choose which 16-byte slice of the EEPROM this device reads. Several devices can therefore share one memory. The completion flag of one device drives the chain reset input of the next device, so the devices load one after another and never use the bus at the same time.

The bus is open-drain. The block drives a line low by raising the matching output-enable and releases the line otherwise. It watches the real line levels, so it follows any other master that holds SCL low for longer.

Top module: `eel_loader`

## Requirements
- R1: Bus activity starts no earlier than START_DLY clock cycles after `cfg_rst_n` rises, and the first START occurs within START_DLY + T_LOW + T_HIGH + 12 cycles.
- R2: The transfer is START, byte 0xA0, word address, repeated START, byte 0xA1. The word address equals the strap value times 16, i.e. `{strap, 4'b0000}`.
- R3: While the bus is busy, every low period of SCL lasts at least T_LOW cycles. Every high period lasts at least T_HIGH cycles, counted from the moment the line is actually high, even when another device stretches the low phase.
- R4: Bytes are 8 bits and sent MSB first. The master acknowledges each of the first 15 received bytes with SDA low. It answers the 16th byte with SDA high (NACK) and then issues one STOP.
- R5: Received byte k (k = 0..15) is stored at register index k, visible on `cfg_regs[8k+7:8k]`.
- R6: `load_ok` goes high only after a complete load with STOP. It then stays high while `cfg_rst_n` and `master_mode` stay high, and both bus enables stay low.
- R7: A NACK after 0xA0, after the word address or after 0xA1 ends the load with a single STOP. In that case no data byte is read, the registers stay zero and `load_ok` stays low.
- R8: While `cfg_rst_n` is low, `load_ok`, all registers and both bus enables are cleared on the next clock. A new rising edge restarts a full load.
- R9: While `master_mode` is low, the block never drives the bus and `load_ok` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rst_n | input | 1 | Active-low load reset; rising edge arms a load (chain input) |
| master_mode | input | 1 | 1 = load configuration from EEPROM |
| strap | input | STRAP_W | Selects the EEPROM slice (start = strap × 16) |
| scl_i | input | 1 | Sensed SCL line level |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_i | input | 1 | Sensed SDA line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| load_ok | output | 1 | Load succeeded; drives the next device's cfg_rst_n |
| cfg_regs | output | NREG*8 | Register file, entry k at bits 8k+7:8k |

## Verification
Bus inputs pass through a two-stage synchronizer. A high phase therefore starts its T_HIGH count two cycles after the line rises, and the bench's line-level run-length monitor gives that slack a margin: it only checks minimum durations.

The start latency after `cfg_rst_n` rises is checked against a window rather than one cycle, because it includes the settling count, the START low/high phases and the synchronizer. Register contents, acknowledge counts and `load_ok` are checked 20 cycles after STOP or after `load_ok` rises; `load_ok` is one register past the STOP completion.

Clear effects from `cfg_rst_n` or `master_mode` appear one clock after the input changes. The bench samples them on the second falling edge after driving the input.

// File: rtl/eel_pkg.sv
package eel_pkg;
  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_STOP  = 2'd1,
    CMD_BIT   = 2'd2
  } cmd_e;
endpackage

// File: rtl/eel_bitphy.sv
// Bit-level engine: START, STOP and single data bits with SCL timing.
// The high phase is timed only once the line is seen high, which makes
// the engine follow slower masters stretching the low phase.
module eel_bitphy
  import eel_pkg::*;
#(
  parameter int T_LOW  = 1250,
  parameter int T_HIGH = 1250
) (
  input  logic clk,
  input  logic clr,
  input  logic cmd_v,
  input  cmd_e cmd,
  input  logic cmd_tx,
  output logic done,
  output logic rx,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_oe,
  output logic sda_oe
);
  localparam int TMAX = (T_LOW > T_HIGH) ? T_LOW : T_HIGH;
  localparam int CW   = $clog2(TMAX + 1);

  typedef enum logic [2:0] {P_IDLE, P_LO, P_RISE, P_HI, P_FIN} ph_e;

  ph_e         st;
  cmd_e        cur;
  logic [CW-1:0] cnt;
  logic [1:0]  scl_s, sda_s;

  always_ff @(posedge clk) begin
    if (clr) begin
      scl_s <= 2'b11;
      sda_s <= 2'b11;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      st     <= P_IDLE;
      cur    <= CMD_BIT;
      cnt    <= '0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      done   <= 1'b0;
      rx     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        P_IDLE: if (cmd_v) begin
          cur <= cmd;
          cnt <= '0;
          st  <= P_LO;
          case (cmd)
            CMD_START: sda_oe <= 1'b0;
            CMD_STOP:  begin sda_oe <= 1'b1; scl_oe <= 1'b1; end
            default:   begin sda_oe <= ~cmd_tx; scl_oe <= 1'b1; end
          endcase
        end
        P_LO: begin
          if (cnt == CW'(T_LOW - 1)) begin
            scl_oe <= 1'b0;
            st     <= P_RISE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        P_RISE: begin
          cnt <= '0;
          if (scl_s[1]) st <= P_HI;
        end
        P_HI: begin
          if (cnt == CW'(T_HIGH - 1) || (cur == CMD_BIT && !scl_s[1])) begin
            cnt <= '0;
            case (cur)
              CMD_BIT: begin
                rx     <= sda_s[1];
                scl_oe <= 1'b1;
                done   <= 1'b1;
                st     <= P_IDLE;
              end
              CMD_START: begin sda_oe <= 1'b1; st <= P_FIN; end
              default:   begin sda_oe <= 1'b0; st <= P_FIN; end
            endcase
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        P_FIN: begin
          if (cnt == CW'(T_HIGH - 1)) begin
            if (cur == CMD_START) scl_oe <= 1'b1;
            done <= 1'b1;
            st   <= P_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eel_seq.sv
// Byte sequencer: addresses the EEPROM, reads NREG bytes, reports result.
module eel_seq
  import eel_pkg::*;
#(
  parameter int         NREG      = 16,
  parameter int         STRAP_W   = 4,
  parameter int         START_DLY = 50000,
  parameter logic [6:0] DEV_ADDR  = 7'h50
) (
  input  logic               clk,
  input  logic               clr,
  input  logic [STRAP_W-1:0] strap,
  output logic               cmd_v,
  output cmd_e               cmd,
  output logic               cmd_tx,
  input  logic               phy_done,
  input  logic               phy_rx,
  output logic               wr_en,
  output logic [$clog2(NREG)-1:0] wr_idx,
  output logic [7:0]         wr_data,
  output logic               load_ok
);
  localparam int IDX_W = $clog2(NREG);
  localparam int DW    = $clog2(START_DLY + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NREG - 1);

  typedef enum logic [2:0] {Q_DLY, Q_START, Q_TX, Q_RX, Q_STOP, Q_END} st_e;

  st_e            st;
  logic [DW-1:0]  dly;
  logic           pend, fail;
  logic [3:0]     bitc;
  logic [7:0]     sh;
  logic [1:0]     tx_idx;
  logic [IDX_W-1:0] rd_idx;
  logic [7:0]     wa_byte;

  assign wa_byte = 8'({strap, {IDX_W{1'b0}}});

  always_ff @(posedge clk) begin
    if (clr) begin
      st      <= Q_DLY;
      dly     <= '0;
      pend    <= 1'b0;
      fail    <= 1'b0;
      bitc    <= '0;
      sh      <= '0;
      tx_idx  <= '0;
      rd_idx  <= '0;
      cmd_v   <= 1'b0;
      cmd     <= CMD_BIT;
      cmd_tx  <= 1'b1;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      load_ok <= 1'b0;
    end else begin
      cmd_v <= 1'b0;
      wr_en <= 1'b0;
      case (st)
        Q_DLY: begin
          if (dly == DW'(START_DLY - 1)) st <= Q_START;
          else dly <= dly + 1'b1;
        end
        Q_START: begin
          if (!pend) begin
            cmd_v <= 1'b1; pend <= 1'b1; cmd <= CMD_START; cmd_tx <= 1'b1;
          end else if (phy_done) begin
            pend <= 1'b0;
            bitc <= '0;
            sh   <= (tx_idx == 2'd2) ? {DEV_ADDR, 1'b1} : {DEV_ADDR, 1'b0};
            st   <= Q_TX;
          end
        end
        Q_TX: begin
          if (!pend) begin
            cmd_v <= 1'b1; pend <= 1'b1; cmd <= CMD_BIT;
            cmd_tx <= (bitc == 4'd8) ? 1'b1 : sh[7];
          end else if (phy_done) begin
            pend <= 1'b0;
            if (bitc != 4'd8) begin
              sh   <= {sh[6:0], 1'b0};
              bitc <= bitc + 1'b1;
            end else if (phy_rx) begin
              fail <= 1'b1;
              st   <= Q_STOP;
            end else begin
              bitc <= '0;
              case (tx_idx)
                2'd0:    begin tx_idx <= 2'd1; sh <= wa_byte; end
                2'd1:    begin tx_idx <= 2'd2; st <= Q_START; end
                default: st <= Q_RX;
              endcase
            end
          end
        end
        Q_RX: begin
          if (!pend) begin
            cmd_v <= 1'b1; pend <= 1'b1; cmd <= CMD_BIT;
            cmd_tx <= (bitc == 4'd8) ? (rd_idx == LAST) : 1'b1;
          end else if (phy_done) begin
            pend <= 1'b0;
            if (bitc != 4'd8) begin
              sh   <= {sh[6:0], phy_rx};
              bitc <= bitc + 1'b1;
            end else begin
              wr_en   <= 1'b1;
              wr_idx  <= rd_idx;
              wr_data <= sh;
              bitc    <= '0;
              if (rd_idx == LAST) st <= Q_STOP;
              else rd_idx <= rd_idx + 1'b1;
            end
          end
        end
        Q_STOP: begin
          if (!pend) begin
            cmd_v <= 1'b1; pend <= 1'b1; cmd <= CMD_STOP; cmd_tx <= 1'b1;
          end else if (phy_done) begin
            pend    <= 1'b0;
            load_ok <= !fail;
            st      <= Q_END;
          end
        end
        default: st <= Q_END;
      endcase
    end
  end
endmodule

// File: rtl/eel_loader.sv
module eel_loader
  import eel_pkg::*;
#(
  parameter int         NREG      = 16,
  parameter int         STRAP_W   = 4,
  parameter int         T_LOW     = 1250,
  parameter int         T_HIGH    = 1250,
  parameter int         START_DLY = 50000,
  parameter logic [6:0] DEV_ADDR  = 7'h50
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_rst_n,
  input  logic               master_mode,
  input  logic [STRAP_W-1:0] strap,
  input  logic               scl_i,
  output logic               scl_oe,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic               load_ok,
  output logic [NREG*8-1:0]  cfg_regs
);
  localparam int IDX_W = $clog2(NREG);

  logic             clr;
  logic             cmd_v, cmd_tx, phy_done, phy_rx, wr_en;
  cmd_e             cmd;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  assign clr = rst | ~cfg_rst_n | ~master_mode;

  eel_seq #(
    .NREG(NREG), .STRAP_W(STRAP_W), .START_DLY(START_DLY), .DEV_ADDR(DEV_ADDR)
  ) u_seq (
    .clk(clk), .clr(clr), .strap(strap),
    .cmd_v(cmd_v), .cmd(cmd), .cmd_tx(cmd_tx),
    .phy_done(phy_done), .phy_rx(phy_rx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .load_ok(load_ok)
  );

  eel_bitphy #(.T_LOW(T_LOW), .T_HIGH(T_HIGH)) u_phy (
    .clk(clk), .clr(clr),
    .cmd_v(cmd_v), .cmd(cmd), .cmd_tx(cmd_tx),
    .done(phy_done), .rx(phy_rx),
    .scl_i(scl_i), .sda_i(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] r;
    always_ff @(posedge clk) begin
      if (clr) r <= '0;
      else if (wr_en && wr_idx == IDX_W'(g)) r <= wr_data;
    end
    assign cfg_regs[g*8 +: 8] = r;
  end
endmodule

// File: rtl/eel_loader_chk.sv
module eel_loader_chk (
  input logic clk,
  input logic rst,
  input logic cfg_rst_n,
  input logic master_mode,
  input logic scl_oe,
  input logic sda_oe,
  input logic load_ok
);
  // R8: holding the load reset clears the flag and frees the bus
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !cfg_rst_n |=> (!load_ok && !scl_oe && !sda_oe));

  // R9: self-load disabled keeps the bus untouched
  p_pinmode_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !master_mode |=> (!load_ok && !scl_oe && !sda_oe));

  // R6: success flag holds while enabled
  p_ok_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (load_ok && cfg_rst_n && master_mode) |=> load_ok);

  // R6: after success the bus is released
  p_ok_bus_free_r6: assert property (@(posedge clk) disable iff (rst)
    load_ok |-> (!scl_oe && !sda_oe));
endmodule

bind eel_loader eel_loader_chk u_chk (
  .clk(clk), .rst(rst), .cfg_rst_n(cfg_rst_n), .master_mode(master_mode),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .load_ok(load_ok)
);

// File: tb/eel_loader_tb.sv
module eel_loader_tb;
  localparam int TL = 10;
  localparam int TH = 8;
  localparam int SD = 60;
  localparam int NR = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_rst_n = 1'b0;
  logic master_mode = 1'b1;
  logic [3:0] strap = 4'd0;
  logic scl_oe, sda_oe, load_ok;
  logic [NR*8-1:0] cfg_regs;
  logic ext_low = 1'b0;
  logic slv_low = 1'b0;
  logic scl_line, sda_line;

  assign scl_line = ~(scl_oe | ext_low);
  assign sda_line = ~(sda_oe | slv_low);

  always #2 clk = ~clk;

  eel_loader #(.NREG(NR), .STRAP_W(4), .T_LOW(TL), .T_HIGH(TH), .START_DLY(SD)) u_dut (
    .clk(clk), .rst(rst), .cfg_rst_n(cfg_rst_n), .master_mode(master_mode),
    .strap(strap), .scl_i(scl_line), .scl_oe(scl_oe), .sda_i(sda_line),
    .sda_oe(sda_oe), .load_ok(load_ok), .cfg_regs(cfg_regs)
  );

  int nchk = 0;
  int nfail = 0;

  // EEPROM model and bus monitor state
  logic [7:0] mem [256];
  int   m_st = 0, bitc = 0, acked = 0, mack = 0, busy = 0;
  logic [7:0] sh = 0, ptr = 0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  int   n_start = 0, n_stop = 0, n_mack = 0, n_mnack = 0;
  int   seen_a0 = 0, seen_a1 = 0, seen_word = -1;
  int   nack_sel = 0, stretch_en = 0, ext_hold = 0, run = 0, tviol = 0;

  always @(negedge clk) begin
    if (rst || !cfg_rst_n) begin
      m_st = 0; bitc = 0; busy = 0; ext_hold = 0;
      slv_low <= 1'b0; ext_low <= 1'b0;
    end else begin
      if (prev_scl && scl_line && prev_sda && !sda_line) begin
        n_start++; busy = 1; m_st = 1; bitc = 0;
      end else if (prev_scl && scl_line && !prev_sda && sda_line) begin
        n_stop++; busy = 0; m_st = 0; slv_low <= 1'b0;
      end else if (!prev_scl && scl_line) begin
        if (m_st == 1 || m_st == 2) begin
          if (bitc < 8) begin sh = {sh[6:0], sda_line}; bitc++; end
        end else if (m_st == 3) begin
          if (bitc < 8) bitc++;
          else if (bitc == 8) begin
            mack = sda_line;
            if (mack != 0) n_mnack++; else n_mack++;
            bitc = 9;
          end
        end
      end else if (prev_scl && !scl_line) begin
        if (stretch_en != 0) ext_hold = 1 + int'($urandom % 15);
        if (m_st == 1 || m_st == 2) begin
          if (bitc == 8) begin
            if (m_st == 1) begin
              if (sh == 8'hA0) seen_a0++;
              if (sh == 8'hA1) seen_a1++;
              acked = ((sh == 8'hA0 && nack_sel != 1) || (sh == 8'hA1 && nack_sel != 3)) ? 1 : 0;
            end else begin
              seen_word = int'(sh);
              acked = (nack_sel != 2) ? 1 : 0;
            end
            slv_low <= (acked != 0);
            bitc = 9;
          end else if (bitc == 9) begin
            slv_low <= 1'b0;
            if (acked == 0) m_st = 0;
            else if (m_st == 2) begin ptr = sh; m_st = 0; end
            else if (sh == 8'hA0) begin m_st = 2; bitc = 0; end
            else begin m_st = 3; bitc = 0; slv_low <= ~mem[ptr][7]; end
          end
        end else if (m_st == 3) begin
          if (bitc >= 1 && bitc < 8) slv_low <= ~mem[ptr][3'(7 - bitc)];
          else if (bitc == 8) slv_low <= 1'b0;
          else if (bitc == 9) begin
            if (mack == 0) begin
              ptr = ptr + 8'd1; bitc = 0; slv_low <= ~mem[ptr][7];
            end else begin
              m_st = 0; slv_low <= 1'b0;
            end
          end
        end
      end
      ext_low <= (ext_hold > 0);
      if (ext_hold > 0) ext_hold--;
    end
    // SCL run-length monitor (R3)
    if (scl_line == prev_scl) run++;
    else begin
      if (busy != 0 && prev_scl && run < TH) tviol++;
      if (busy != 0 && !prev_scl && run < TL) tviol++;
      run = 1;
    end
    prev_scl = scl_line;
    prev_sda = sda_line;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_byte(input logic [3:0] s, input int i);
    return int'(mem[{s, 4'b0000} + 8'(i)]);
  endfunction

  function automatic int regs_zero();
    return (cfg_regs == '0) ? 1 : 0;
  endfunction

  int lat = 0;

  task automatic start_load(input logic [3:0] s, input int nk, input int st_en);
    @(negedge clk);
    cfg_rst_n = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    strap = s; nack_sel = nk; stretch_en = st_en;
    n_start = 0; n_stop = 0; n_mack = 0; n_mnack = 0;
    seen_a0 = 0; seen_a1 = 0; seen_word = -1; tviol = 0;
    repeat (3) @(negedge clk);
    cfg_rst_n = 1'b1;
    lat = 0;
    while (!sda_oe && !scl_oe && lat < SD + 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic wait_end();
    int t;
    t = 0;
    while (!load_ok && n_stop == 0 && t < 40000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 40000, "R6", "load finished in time", t, 0);
    repeat (20) @(negedge clk);
  endtask

  task automatic good_load(input logic [3:0] s, input int st_en);
    int bad;
    int first;
    start_load(s, 0, st_en);
    chk(lat >= SD && lat <= SD + TL + TH + 12, "R1", "start latency", lat, SD);
    wait_end();
    chk(seen_a0 == 1 && seen_a1 == 1 && n_start == 2, "R2", "A0/A1 with repeated START",
        seen_a0 * 100 + seen_a1 * 10 + n_start, 112);
    chk(seen_word == int'(s) * 16, "R2", "word address", seen_word, int'(s) * 16);
    chk(tviol == 0, "R3", "SCL low/high period violations", tviol, 0);
    chk(n_mack == NR - 1 && n_mnack == 1 && n_stop == 1, "R4", "ACK/NACK/STOP count",
        n_mack * 100 + n_mnack * 10 + n_stop, (NR - 1) * 100 + 11);
    bad = 0; first = -1;
    for (int i = 0; i < NR; i++)
      if (int'(cfg_regs[i*8 +: 8]) != exp_byte(s, i)) begin
        bad++;
        if (first < 0) first = i;
      end
    chk(bad == 0, "R5", "register file vs EEPROM slice",
        (first < 0) ? 0 : int'(cfg_regs[first*8 +: 8]), (first < 0) ? 0 : exp_byte(s, first));
    chk(load_ok == 1'b1, "R6", "load_ok after success", int'(load_ok), 1);
  endtask

  task automatic bad_load(input int nk);
    start_load(4'($urandom), nk, 0);
    wait_end();
    repeat (300) @(negedge clk);
    chk(load_ok == 1'b0, "R7", "load_ok after NACK", int'(load_ok), 0);
    chk(n_stop == 1 && (n_mack + n_mnack) == 0, "R7", "single STOP and no reads",
        n_stop * 100 + n_mack + n_mnack, 100);
    chk(regs_zero() == 1 && !scl_oe && !sda_oe, "R7", "registers zero and bus free",
        regs_zero(), 1);
  endtask

  // watchdog
  initial begin
    repeat (195000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int act;
    void'($urandom(32'h1A2B3C));
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(load_ok == 1'b0 && regs_zero() == 1 && !scl_oe && !sda_oe, "R8", "reset state",
        int'(load_ok) + 2 * int'(scl_oe) + 4 * int'(sda_oe), 0);

    // directed strap corners
    good_load(4'h0, 0);
    // R6: flag holds
    repeat (200) @(negedge clk);
    chk(load_ok == 1'b1 && !scl_oe && !sda_oe, "R6", "load_ok held, bus idle", int'(load_ok), 1);
    good_load(4'hF, 0);
    // R3: forced stretching by another device
    good_load(4'h5, 1);
    // random straps and stretching
    for (int k = 0; k < 3; k++) good_load(4'($urandom), int'($urandom % 2));

    // R7: NACK at each addressing byte
    bad_load(1);
    bad_load(2);
    bad_load(3);

    // R8: reset in the middle of reading
    start_load(4'h9, 0, 0);
    act = 0;
    while (n_mack < 4 && act < 20000) begin @(negedge clk); act++; end
    cfg_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(load_ok == 1'b0 && regs_zero() == 1 && !scl_oe && !sda_oe, "R8",
        "clear during load", regs_zero(), 1);
    good_load(4'h9, 0);

    // R9: self-load disabled
    @(negedge clk);
    master_mode = 1'b0;
    cfg_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(load_ok == 1'b0 && regs_zero() == 1, "R9", "mode off clears", int'(load_ok), 0);
    cfg_rst_n = 1'b1;
    act = 0;
    for (int i = 0; i < SD + 40 * (TL + TH); i++) begin
      @(negedge clk);
      if (scl_oe || sda_oe) act++;
    end
    chk(act == 0 && load_ok == 1'b0, "R9", "no bus activity with mode off", act, 0);
    master_mode = 1'b1;
    good_load(4'h3, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule